// File: doc/BRIEF.md
# Base64 Stream Decoder with Symbol Validation

This block turns a stream of base64 text, one character per handshake, back into binary bytes, one byte per handshake. Each character is looked up in a reverse table. An entry holds either a six-bit symbol value or a marker meaning "not part of the alphabet". Every group of four symbol values is merged into three bytes. A group whose last one or two characters are the pad character yields fewer bytes. The final character of a message is flagged by the sender, and the final byte produced is flagged the same way.

Malformed input is reported and never silently decoded. Three kinds of fault count as malformed: a character outside the alphabet, misplaced padding, and a message whose length is not a multiple of four. On any of these the block raises a sticky error flag. It then swallows the rest of the message without producing output.

The reverse table comes up holding the standard alphabet. It can be rewritten at runtime while the decoder is idle, which lets the same hardware serve other alphabet variants, such as the URL-safe one.

Top module: `b64_dec`

## Requirements
- R1: With the reset table, characters A–Z, a–z, 0–9, '+' and '/' map to values 0–25, 26–51, 52–61, 62 and 63. Each four values a, b, c, d produce, in this order, the bytes (a<<2)|(b>>4), ((b<<4)&0xFF)|(c>>2) and ((c<<6)&0xFF)|d.
- R2: Any accepted character with bit 7 set is an error, and `err` is high from the next cycle.
- R3: A character whose table entry has bit 6 set is an error. A table entry is 7 bits: bit 6 is the invalid marker and bits 5:0 are the symbol value. The pad character (0x3D) is never looked up.
- R4: In the final group, "xx==" yields one byte and "xxx=" yields two bytes. `out_last` is high on the final byte of a message that decodes without error.
- R5: A pad character in the first or second position of a group is an error. So is a non-pad character after a pad, and a pad in any group other than the last.
- R6: A message whose length is not a multiple of four characters is an error. Complete groups before the fault still produce their bytes; the partial group produces none.
- R7: Once raised, `err` stays high until the first character of the next message is accepted. From the faulty character to the end of the message, no byte is produced.
- R8: A write on the table port while the decoder is idle replaces the addressed entry, and later messages decode with it. The port is 7 bits wide and indexes the character code with bit 7 removed.
- R9: A table write while a message is in progress or output is pending is ignored.
- R10: `out_byte` and `out_last` hold while `out_valid` is high and `out_ready` is low. `in_ready` is low whenever output is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Character available |
| in_ready | output | 1 | Decoder accepts a character |
| in_char | input | 8 | ASCII character |
| in_last | input | 1 | Character is the final one of the message |
| out_valid | output | 1 | Decoded byte available |
| out_ready | input | 1 | Consumer accepts the byte |
| out_byte | output | 8 | Decoded byte |
| out_last | output | 1 | Byte is the final one of the message |
| err | output | 1 | Sticky malformed-message flag |
| tbl_we | input | 1 | Reverse-table write strobe |
| tbl_addr | input | 7 | Table index (character code bits 6:0) |
| tbl_data | input | 7 | Table entry: bit 6 invalid marker, bits 5:0 value |

## Verification
The hardest case to reach is a table write that arrives in the middle of a message, since the idle window closes as soon as the first character is taken. The bench raises the write strobe together with a chosen character inside a message. It aims that write at a character the message itself uses, and then decodes the same message again, so that a write which wrongly took effect would corrupt the second result. A second hard area is faults that follow valid groups in the same message. Messages with a good first group and a bad second group, or the reverse order, show that bytes stop exactly at the fault.

// File: rtl/b64_pkg.sv
package b64_pkg;
  localparam int SYM_W = 6;
  localparam int ENT_W = SYM_W + 1;
  localparam logic [ENT_W-1:0] BAD_ENT = 7'h40;

  // Reset-time reverse table content for the standard alphabet.
  function automatic logic [ENT_W-1:0] std_entry(input logic [6:0] ch);
    if (ch >= 7'h41 && ch <= 7'h5A) return ch - 7'd65;
    if (ch >= 7'h61 && ch <= 7'h7A) return ch - 7'd71;
    if (ch >= 7'h30 && ch <= 7'h39) return ch + 7'd4;
    if (ch == 7'h2B) return 7'd62;
    if (ch == 7'h2F) return 7'd63;
    return BAD_ENT;
  endfunction

  // Merge four six-bit values into three bytes, first byte in the top lane.
  function automatic logic [23:0] join_quad(input logic [5:0] a, input logic [5:0] b,
                                            input logic [5:0] c, input logic [5:0] d);
    logic [7:0] y0, y1, y2;
    y0 = (8'(a) << 2) | 8'(b >> 4);
    y1 = (8'(b) << 4) | 8'(c >> 2);
    y2 = (8'(c) << 6) | 8'(d);
    return {y0, y1, y2};
  endfunction

  // Byte yield of the closing group given where padding started.
  function automatic logic [1:0] quad_yield(input logic pad_third, input logic pad_fourth);
    if (pad_third)  return 2'd1;
    if (pad_fourth) return 2'd2;
    return 2'd3;
  endfunction
endpackage

// File: rtl/b64_lut.sv
module b64_lut
  import b64_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [ENT_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [ENT_W-1:0] rdata
);
  localparam int DEPTH = 2 ** IDX_W;

  logic [ENT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= std_entry(7'(i));
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/b64_quad.sv
module b64_quad
  import b64_pkg::*;
#(
  parameter int          CHAR_W   = 8,
  parameter logic [7:0]  PAD_CHAR = 8'h3D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [CHAR_W-1:0] ch,
  input  logic              last,
  input  logic [ENT_W-1:0]  ent,
  output logic              in_msg,
  output logic              err,
  output logic              done,
  output logic [23:0]       dbytes,
  output logic [1:0]        dn,
  output logic              dlast
);
  localparam int ACC_W = 3 * SYM_W;

  logic [1:0]       pos;
  logic [ACC_W-1:0] acc;
  logic             pad2;
  logic             in_msg_q, err_q;

  logic             skip, is_pad, bad_sym, err_now;
  logic [SYM_W-1:0] val;

  assign skip    = in_msg_q & err_q;
  assign is_pad  = (ch == PAD_CHAR);
  assign bad_sym = ch[CHAR_W-1] | ent[ENT_W-1];
  assign val     = is_pad ? '0 : ent[SYM_W-1:0];

  always_comb begin
    if (is_pad) begin
      case (pos)
        2'd0, 2'd1: err_now = 1'b1;
        2'd2:       err_now = last;
        default:    err_now = !last;
      endcase
    end else begin
      err_now = bad_sym | pad2 | (last & (pos != 2'd3));
    end
  end

  assign done   = fire & !skip & !err_now & (pos == 2'd3);
  assign dbytes = join_quad(acc[3*SYM_W-1:2*SYM_W], acc[2*SYM_W-1:SYM_W], acc[SYM_W-1:0], val);
  assign dn     = quad_yield(pad2, is_pad);
  assign dlast  = last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos      <= '0;
      acc      <= '0;
      pad2     <= 1'b0;
      in_msg_q <= 1'b0;
      err_q    <= 1'b0;
    end else if (fire) begin
      in_msg_q <= !last;
      err_q    <= (in_msg_q & err_q) | (!skip & err_now);
      if (skip || err_now || pos == 2'd3 || last) begin
        pos  <= '0;
        pad2 <= 1'b0;
      end else begin
        pos  <= pos + 2'd1;
        pad2 <= (pos == 2'd2) & is_pad;
        acc  <= {acc[ACC_W-SYM_W-1:0], val};
      end
    end
  end

  assign in_msg = in_msg_q;
  assign err    = err_q;
endmodule

// File: rtl/b64_obuf.sv
module b64_obuf (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [23:0] ldata,
  input  logic [1:0]  ln,
  input  logic        llast,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_byte,
  output logic        out_last,
  output logic        empty
);
  logic [23:0] data;
  logic [1:0]  cnt;
  logic        last_q;
  logic        pop;

  assign pop = out_valid & out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data   <= '0;
      cnt    <= '0;
      last_q <= 1'b0;
    end else if (load) begin
      data   <= ldata;
      cnt    <= ln;
      last_q <= llast;
    end else if (pop) begin
      data <= {data[15:0], 8'h00};
      cnt  <= cnt - 2'd1;
    end
  end

  assign empty     = (cnt == 2'd0);
  assign out_valid = !empty;
  assign out_byte  = data[23:16];
  assign out_last  = last_q & (cnt == 2'd1);
endmodule

// File: rtl/b64_dec.sv
module b64_dec
  import b64_pkg::*;
#(
  parameter int         CHAR_W   = 8,
  parameter logic [7:0] PAD_CHAR = 8'h3D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_char,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_byte,
  output logic              out_last,
  output logic              err,
  input  logic              tbl_we,
  input  logic [CHAR_W-2:0] tbl_addr,
  input  logic [ENT_W-1:0]  tbl_data
);
  localparam int IDX_W = CHAR_W - 1;

  logic             fire, in_msg, obuf_empty, tbl_wr_ok;
  logic [ENT_W-1:0] ent;
  logic             q_done, q_last;
  logic [23:0]      q_bytes;
  logic [1:0]       q_n;

  assign in_ready  = obuf_empty;
  assign fire      = in_valid & in_ready;
  assign tbl_wr_ok = tbl_we & !in_msg & obuf_empty;

  b64_lut #(.IDX_W(IDX_W)) u_lut (
    .clk(clk), .rst_n(rst_n), .we(tbl_wr_ok), .waddr(tbl_addr), .wdata(tbl_data),
    .raddr(in_char[IDX_W-1:0]), .rdata(ent)
  );

  b64_quad #(.CHAR_W(CHAR_W), .PAD_CHAR(PAD_CHAR)) u_quad (
    .clk(clk), .rst_n(rst_n), .fire(fire), .ch(in_char), .last(in_last), .ent(ent),
    .in_msg(in_msg), .err(err), .done(q_done), .dbytes(q_bytes), .dn(q_n), .dlast(q_last)
  );

  b64_obuf u_obuf (
    .clk(clk), .rst_n(rst_n), .load(q_done), .ldata(q_bytes), .ln(q_n), .llast(q_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
    .out_last(out_last), .empty(obuf_empty)
  );
endmodule

// File: rtl/b64_dec_chk.sv
module b64_dec_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_char,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_byte,
  input logic       out_last,
  input logic       err,
  input logic       tbl_wr_ok
);
  p_high_bit_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_char[7] |=> err);

  p_last_with_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err && !(in_valid && in_ready) |=> err);

  p_silent_on_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !out_valid);

  p_write_only_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr_ok |-> !out_valid && in_ready);

  p_hold_output_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_last));

  p_stall_input_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
endmodule

bind b64_dec b64_dec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_char(in_char),
  .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte), .out_last(out_last),
  .err(err), .tbl_wr_ok(tbl_wr_ok)
);

// File: tb/test_b64_dec.sv
`timescale 1ns/1ps
module test_b64_dec;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0, tbl_we = 1'b0;
  logic [7:0] in_char = 8'h00;
  logic [6:0] tbl_addr = '0, tbl_data = '0;
  logic       in_ready, out_valid, out_last, err;
  logic [7:0] out_byte;

  int checks = 0, errors = 0, cyc = 0;
  logic [8:0] exp_q[$];
  bit url_mode = 0;
  string req_now = "R1";

  always #2 clk = ~clk;

  b64_dec i_b64_dec (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_char(in_char),
    .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
    .out_last(out_last), .err(err), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int sym_of(input byte ch);
    string al;
    al = "ABCDEFGHIJKLMNOPQRSTUVWXYZabcdefghijklmnopqrstuvwxyz0123456789+/";
    if (url_mode) begin al[62] = "-"; al[63] = "_"; end
    for (int i = 0; i < 64; i++) if (al[i] == ch) return i;
    return -1;
  endfunction

  // Reference: decode group by group, stop at the first fault.
  function automatic bit model(input string s);
    int n, ng, v[4];
    bit fin;
    n = s.len();
    ng = n / 4;
    for (int g = 0; g < ng; g++) begin
      fin = (g == ng - 1) && (n % 4 == 0);
      for (int k = 0; k < 4; k++) v[k] = (s[4*g+k] == "=") ? -2 : sym_of(s[4*g+k]);
      if (v[0] < 0 || v[1] < 0) return 1;
      if (v[2] == -1 || v[3] == -1) return 1;
      if (v[2] == -2 && v[3] != -2) return 1;
      if ((v[2] == -2 || v[3] == -2) && !fin) return 1;
      begin
        int cnt, bits;
        cnt = (v[2] == -2) ? 1 : (v[3] == -2) ? 2 : 3;
        bits = v[0] * 262144 + v[1] * 4096 + (v[2] < 0 ? 0 : v[2]) * 64 + (v[3] < 0 ? 0 : v[3]);
        for (int k = 0; k < cnt; k++)
          exp_q.push_back({fin && (k == cnt - 1), 8'((bits >> (16 - 8 * k)) & 255)});
      end
    end
    return (n % 4 != 0);
  endfunction

  // Output monitor with a fixed backpressure pattern.
  always @(negedge clk) begin
    logic rdy;
    cyc++;
    rdy = (cyc % 3 != 1);
    out_ready = rdy;
    if (rst_n && out_valid && rdy) begin
      if (exp_q.size() == 0) chk(0, req_now, "unexpected byte", out_byte, 0);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk(out_byte == e[7:0], req_now, "byte", out_byte, e[7:0]);
        chk(out_last == e[8], req_now, "last flag", out_last, e[8]);
      end
    end
  end

  task automatic send(input string s, input int wr_at, input logic [6:0] wa, input logic [6:0] wd);
    for (int i = 0; i < s.len(); i++) begin
      in_valid = 1'b1; in_char = s[i]; in_last = (i == s.len() - 1);
      if (i == wr_at) begin tbl_we = 1'b1; tbl_addr = wa; tbl_data = wd; end
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      tbl_we = 1'b0;
    end
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic run(input string req, input string s, input int wr_at = -1,
                     input logic [6:0] wa = 0, input logic [6:0] wd = 0);
    bit e;
    req_now = req;
    e = model(s);
    send(s, wr_at, wa, wd);
    for (int i = 0; i < 30 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, req, {"missing bytes for ", s}, exp_q.size(), 0);
    exp_q.delete();
    chk(err == e, req, {"error flag for ", s}, err, e);
  endtask

  task automatic tbl_write(input logic [6:0] a, input logic [6:0] d);
    tbl_we = 1'b1; tbl_addr = a; tbl_data = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 0, "R10", "reset out_valid", out_valid, 0);
    chk(in_ready == 1, "R10", "reset in_ready", in_ready, 1);
    chk(err == 0, "R7", "reset err", err, 0);

    run("R1", "QUJD");
    run("R1", "TWFu");
    run("R1", "SGVsbG8gd29ybGQh");
    run("R1", "ABCDEFGHIJKLMNOPQRSTUVWXYZabcdefghijklmnopqrstuvwxyz0123456789+/");
    run("R4", "TWE=");
    run("R4", "TQ==");
    run("R2", "QU\x80D");
    run("R7", "QUJD");
    run("R3", "QU*D");
    run("R3", "QUJD=UJD");
    run("R5", "Q===");
    run("R5", "=QUJ");
    run("R5", "QQ=AQUJD");
    run("R5", "QQ==QUJD");
    run("R6", "QUJDQQ");
    run("R6", "QUJDQ");
    run("R7", "QU*DQUJD");
    run("R7", "TWFu");
    // R9: write aimed at 'Q' mid-message must not take effect
    run("R9", "QUJD", 2, 7'h51, 7'h40);
    run("R9", "QUJD");
    // R8: switch to the URL-safe alphabet while idle
    tbl_write(7'h2D, 7'd62);
    tbl_write(7'h5F, 7'd63);
    tbl_write(7'h2B, 7'h40);
    tbl_write(7'h2F, 7'h40);
    url_mode = 1;
    run("R8", "-_-_");
    run("R8", "+/+/");
    run("R8", "QUJD");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule